// File: doc/BRIEF.md
# Card-Paid Vending Transaction Controller

This block sequences one card-paid sale for a machine with twenty product slots. A transaction opens when a card is detected while the controller is idle. The buyer then keys a two-digit slot number on a shared 4-bit digit bus, one digit per strobe. The controller checks the number against the slot range and the slot's remaining stock, and shows the price. It then waits for the bank's approval. On approval it removes one unit from the slot's stock count and raises the vend output until the door has been opened and closed again.

Every wait in the sequence is bounded by the same timeout window: the wait for each digit, for approval and for the door to open. A missing digit or a bad number produces a one-cycle invalid-selection pulse. A missing approval produces a one-cycle failed-payment pulse. A door that never opens simply ends the vend. Stock counts live inside the block. They are zeroed by reset and filled to capacity by a reload request, which is accepted only while idle.

Top module: `vend_txn_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after its release, `vend`, `bad_sel`, `pay_fail` are 0 and `price` is 0. Reset leaves every slot's stock at 0, so a valid-looking code entered before any reload is rejected with `bad_sel`.
- R2: `reload` fills every slot to 10 units only when the controller is idle. While idle, `reload` takes priority over `card_in`, so no transaction starts in that cycle. A `reload` held during a transaction has no effect on stock.
- R3: The tens digit is taken from `key_digit` in the first cycle with `key_press` high after the card opens the transaction. The units digit is taken in the next such cycle. Cycles with `key_press` low are ignored.
- R4: If no digit is strobed within 5 cycles of the wait for that digit starting (tens or units), `bad_sel` pulses as the controller returns to idle. A strobe in the 5th cycle is still accepted.
- R5: A code is rejected with `bad_sel` when either digit exceeds 9, when tens*10+units exceeds 19, or when the slot's stock is 0.
- R6: `price` shows 1 for codes 0-3, 2 for 4-7, 3 for 8-11, 4 for 12-15, 5 for 16-17 and 6 for 18-19, in the cycle after the units digit of a valid code. It holds through the rest of the transaction and idle, and returns to 0 in the cycle after a new transaction starts.
- R7: After a valid code, if `pay_ok` is not high in any of the next 5 cycles, `pay_fail` pulses and the controller returns to idle. Approval in the 5th cycle is accepted.
- R8: On approval, `vend` rises in the next cycle and the chosen slot loses one unit. After 10 approved sales from a full slot, the 11th selection of it is rejected.
- R9: `vend` stays high until the door has been seen high and then low. It falls in the cycle after `door_open` goes low.
- R10: If `door_open` does not go high within 5 cycles of `vend` rising, `vend` falls after the 5th cycle.
- R11: `bad_sel` and `pay_fail` are each high for exactly one cycle per event and never together. The controller is idle while they are high.
- R12: Reset takes priority over `reload`: with both high, stock ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reload | input | 1 | Request to fill all slots to capacity |
| card_in | input | 1 | Card present |
| key_press | input | 1 | Strobe qualifying `key_digit` |
| key_digit | input | 4 | Keypad digit, binary |
| pay_ok | input | 1 | Bank approval |
| door_open | input | 1 | Delivery door is open |
| vend | output | 1 | Dispense in progress |
| bad_sel | output | 1 | One-cycle invalid-selection pulse |
| pay_fail | output | 1 | One-cycle failed-payment pulse |
| price | output | 3 | Price of the current selection |

## Verification
The hardest condition to reach from the ports is an empty slot whose count was brought down by sales rather than by reset. Reaching it takes a reload followed by ten complete approved sales from the same slot, each with a full door open-and-close cycle, before the eleventh selection can be shown to fail. The bench does this in a loop and then holds `reload` high through a transaction to show that the slot stays empty. It finishes with an idle reload that makes the slot sell again. The timeout edges are reached by counting idle cycles before a strobe, approval or door event, and acting in exactly the 5th cycle or withholding it.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int DIGIT_W = 4;
  localparam int CODE_W  = 8;
  localparam int PRICE_W = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_DIG_HI, S_DIG_LO, S_PAY, S_DOOR_WAIT, S_DOOR_OPEN
  } txn_state_t;

  // a keypad digit is decimal
  function automatic logic digit_ok(input logic [DIGIT_W-1:0] d);
    return d <= DIGIT_W'(9);
  endfunction

  function automatic logic [CODE_W-1:0] join_code(input logic [DIGIT_W-1:0] hi,
                                                  input logic [DIGIT_W-1:0] lo);
    return (CODE_W'(hi) << 3) + (CODE_W'(hi) << 1) + CODE_W'(lo);
  endfunction

  // price bands: four-wide bands up to 15, then pairs
  function automatic logic [PRICE_W-1:0] price_of(input logic [CODE_W-1:0] c);
    if (c < CODE_W'(16)) return PRICE_W'(c[CODE_W-1:2]) + PRICE_W'(1);
    else if (c < CODE_W'(18)) return PRICE_W'(5);
    else return PRICE_W'(6);
  endfunction
endpackage

// File: rtl/vend_timer.sv
module vend_timer #(
  parameter int WAIT_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expired
);
  localparam int TW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (!expired)  cnt_q <= cnt_q + TW'(1);
  end

  assign expired = (cnt_q == TW'(WAIT_CYC - 1));
endmodule

// File: rtl/vend_stock.sv
module vend_stock #(
  parameter int NUM_SLOTS = 20,
  parameter int SLOT_CAP  = 10,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill,
  input  logic             dec_en,
  input  logic [IDX_W-1:0] dec_idx,
  input  logic [IDX_W-1:0] look_idx,
  output logic             look_nonzero
);
  localparam int CNT_W = $clog2(SLOT_CAP + 1);
  localparam int PAD_N = 1 << IDX_W;

  logic [NUM_SLOTS-1:0] nz;
  logic [PAD_N-1:0]     nz_pad;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else if (fill) cnt_q <= CNT_W'(SLOT_CAP);
      else if (dec_en && dec_idx == IDX_W'(i) && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
    end
    assign nz[i] = (cnt_q != '0);
  end

  always_comb begin
    nz_pad = '0;
    nz_pad[NUM_SLOTS-1:0] = nz;
  end

  assign look_nonzero = nz_pad[look_idx];
endmodule

// File: rtl/vend_txn_ctrl.sv
module vend_txn_ctrl
  import vend_pkg::*;
#(
  parameter int NUM_SLOTS = 20,
  parameter int SLOT_CAP  = 10,
  parameter int WAIT_CYC  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reload,
  input  logic               card_in,
  input  logic               key_press,
  input  logic [DIGIT_W-1:0] key_digit,
  input  logic               pay_ok,
  input  logic               door_open,
  output logic               vend,
  output logic               bad_sel,
  output logic               pay_fail,
  output logic [PRICE_W-1:0] price
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  txn_state_t         st_q, st_nx;
  logic [DIGIT_W-1:0] hi_q;
  logic [IDX_W-1:0]   slot_q;
  logic [PRICE_W-1:0] price_q;
  logic               bad_q, fail_q;

  // named internal events
  logic               txn_start, hi_load, sel_accept, inv_set, fail_set, stock_dec;
  logic               tmo, fill, slot_has_stock, code_ok;
  logic [CODE_W-1:0]  code;

  assign code    = join_code(hi_q, key_digit);
  assign code_ok = digit_ok(hi_q) && digit_ok(key_digit) && (code < CODE_W'(NUM_SLOTS));
  assign fill    = reload && (st_q == S_IDLE);

  vend_stock #(.NUM_SLOTS(NUM_SLOTS), .SLOT_CAP(SLOT_CAP)) u_stock (
    .clk(clk), .rst(rst), .fill(fill),
    .dec_en(stock_dec), .dec_idx(slot_q),
    .look_idx(code[IDX_W-1:0]), .look_nonzero(slot_has_stock)
  );

  vend_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk(clk), .rst(rst), .restart(st_nx != st_q), .expired(tmo)
  );

  always_comb begin
    st_nx = st_q;
    txn_start = 1'b0; hi_load = 1'b0; sel_accept = 1'b0;
    inv_set = 1'b0; fail_set = 1'b0; stock_dec = 1'b0;
    unique case (st_q)
      S_IDLE: if (!reload && card_in) begin
        txn_start = 1'b1; st_nx = S_DIG_HI;
      end
      S_DIG_HI: if (key_press) begin
        hi_load = 1'b1; st_nx = S_DIG_LO;
      end else if (tmo) begin
        inv_set = 1'b1; st_nx = S_IDLE;
      end
      S_DIG_LO: if (key_press) begin
        if (code_ok && slot_has_stock) begin
          sel_accept = 1'b1; st_nx = S_PAY;
        end else begin
          inv_set = 1'b1; st_nx = S_IDLE;
        end
      end else if (tmo) begin
        inv_set = 1'b1; st_nx = S_IDLE;
      end
      S_PAY: if (pay_ok) begin
        stock_dec = 1'b1; st_nx = S_DOOR_WAIT;
      end else if (tmo) begin
        fail_set = 1'b1; st_nx = S_IDLE;
      end
      S_DOOR_WAIT: if (door_open) st_nx = S_DOOR_OPEN;
                   else if (tmo)  st_nx = S_IDLE;
      S_DOOR_OPEN: if (!door_open) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      hi_q    <= '0;
      slot_q  <= '0;
      price_q <= '0;
      bad_q   <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      st_q   <= st_nx;
      bad_q  <= inv_set;
      fail_q <= fail_set;
      if (hi_load) hi_q <= key_digit;
      if (sel_accept) begin
        slot_q  <= code[IDX_W-1:0];
        price_q <= price_of(code);
      end else if (txn_start) begin
        price_q <= '0;
      end
    end
  end

  assign vend     = (st_q == S_DOOR_WAIT) || (st_q == S_DOOR_OPEN);
  assign bad_sel  = bad_q;
  assign pay_fail = fail_q;
  assign price    = price_q;
endmodule

// File: rtl/vend_txn_chk.sv
module vend_txn_chk (
  input logic       clk,
  input logic       rst,
  input logic       vend,
  input logic       bad_sel,
  input logic       pay_fail,
  input logic [2:0] price,
  input logic       pay_ok,
  input logic       door_open,
  input logic       txn_start,
  input logic       stock_dec
);
  p_flags_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(bad_sel && pay_fail));
  p_bad_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    bad_sel |=> !bad_sel);
  p_fail_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    pay_fail |=> !pay_fail);
  p_vend_on_approve_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(vend) |-> $past(pay_ok));
  p_dec_then_vend_r8: assert property (@(posedge clk) disable iff (rst)
    stock_dec |=> vend);
  p_price_during_vend_r6: assert property (@(posedge clk) disable iff (rst)
    vend |-> (price != 3'd0 && price <= 3'd6));
  p_price_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (vend && $past(vend)) |-> $stable(price));
  p_start_clears_r6: assert property (@(posedge clk) disable iff (rst)
    txn_start |=> (price == 3'd0));
  p_door_close_r9: assert property (@(posedge clk) disable iff (rst)
    (vend && $past(vend) && $past(door_open) && !door_open) |=> !vend);
  p_no_flag_in_vend_r10: assert property (@(posedge clk) disable iff (rst)
    vend |-> (!bad_sel && !pay_fail));
endmodule

bind vend_txn_ctrl vend_txn_chk u_chk (
  .clk(clk), .rst(rst), .vend(vend), .bad_sel(bad_sel), .pay_fail(pay_fail),
  .price(price), .pay_ok(pay_ok), .door_open(door_open),
  .txn_start(txn_start), .stock_dec(stock_dec)
);

// File: tb/vend_txn_ctrl_tb.sv
module vend_txn_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1, reload = 1'b0, card_in = 1'b0, key_press = 1'b0;
  logic [3:0] key_digit = 4'd0;
  logic       pay_ok = 1'b0, door_open = 1'b0;
  logic       vend, bad_sel, pay_fail;
  logic [2:0] price;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  vend_txn_ctrl u_dut (
    .clk(clk), .rst(rst), .reload(reload), .card_in(card_in),
    .key_press(key_press), .key_digit(key_digit), .pay_ok(pay_ok),
    .door_open(door_open), .vend(vend), .bad_sel(bad_sel),
    .pay_fail(pay_fail), .price(price)
  );

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_price(int c);
    int b;
    b = 6;
    if (c <= 17) b = 5;
    if (c <= 15) b = 4;
    if (c <= 11) b = 3;
    if (c <= 7)  b = 2;
    if (c <= 3)  b = 1;
    return b;
  endfunction

  task automatic start_txn();
    card_in = 1'b1; tick(); card_in = 1'b0;
  endtask

  task automatic enter(int hi, int lo);
    key_press = 1'b1; key_digit = 4'(hi); tick();
    key_digit = 4'(lo); tick(); key_press = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; repeat (2) tick(); rst = 1'b0; tick();
  endtask

  task automatic reload_idle();
    reload = 1'b1; tick(); reload = 1'b0;
  endtask

  // full approved sale, checking price, vend and the door handshake
  task automatic buy(int hi, int lo, string req);
    start_txn();
    chk("R6", "price cleared at start", price, 0);
    enter(hi, lo);
    chk(req, "bad_sel on valid code", bad_sel, 0);
    chk("R6", "price shown", price, exp_price(hi * 10 + lo));
    pay_ok = 1'b1; tick(); pay_ok = 1'b0;
    chk("R8", "vend after approval", vend, 1);
    door_open = 1'b1; tick();
    chk("R9", "vend held while door open", vend, 1);
    tick();
    chk("R9", "vend held until door closes", vend, 1);
    door_open = 1'b0; tick();
    chk("R9", "vend dropped after close", vend, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; reload = 1'b1; repeat (3) tick();
    chk("R1", "vend in reset", vend, 0);
    chk("R1", "bad_sel in reset", bad_sel, 0);
    chk("R1", "price in reset", price, 0);
    rst = 1'b0; reload = 1'b0; tick();
    chk("R1", "pay_fail after reset", pay_fail, 0);
    start_txn(); enter(0, 5);
    chk("R12", "empty after reset with reload held", bad_sel, 1);
    tick();
    chk("R11", "bad_sel one cycle", bad_sel, 0);
  endtask

  task automatic t_reload_beats_card();
    int seen;
    seen = 0;
    reload = 1'b1; card_in = 1'b1; tick();
    reload = 1'b0; card_in = 1'b0;
    for (int i = 0; i < 8; i++) begin tick(); seen += int'(bad_sel); end
    chk("R2", "no transaction started during reload", seen, 0);
  endtask

  task automatic t_gap_digits();
    start_txn();
    key_press = 1'b1; key_digit = 4'd0; tick();
    key_press = 1'b0; key_digit = 4'd3; repeat (3) tick();
    key_press = 1'b1; key_digit = 4'd9; tick(); key_press = 1'b0;
    chk("R3", "unstrobed cycles ignored, price of 09", price, 3);
    chk("R3", "no bad_sel", bad_sel, 0);
    repeat (5) tick();
    chk("R7", "payment timeout flag", pay_fail, 1);
  endtask

  task automatic t_price_sweep();
    for (int c = 0; c < 20; c++) begin
      start_txn(); enter(c / 10, c % 10);
      chk("R6", $sformatf("price code %0d", c), price, exp_price(c));
      repeat (4) tick();
      chk("R7", "no fail before 5th cycle", pay_fail, 0);
      tick();
      chk("R7", "fail after 5 cycles", pay_fail, 1);
      tick();
      chk("R11", "pay_fail one cycle", pay_fail, 0);
      chk("R6", "price held in idle", price, exp_price(c));
    end
  endtask

  task automatic t_late_approval();
    start_txn(); enter(1, 2);
    repeat (4) tick();
    pay_ok = 1'b1; tick(); pay_ok = 1'b0;
    chk("R7", "approval in 5th cycle vends", vend, 1);
    chk("R7", "no fail on late approval", pay_fail, 0);
    repeat (4) tick();
    chk("R10", "vend held before door timeout", vend, 1);
    tick();
    chk("R10", "vend dropped on door timeout", vend, 0);
  endtask

  task automatic t_digit_timeouts();
    start_txn(); repeat (4) tick();
    chk("R4", "no flag before tens timeout", bad_sel, 0);
    tick();
    chk("R4", "tens digit timeout", bad_sel, 1);
    tick();
    chk("R11", "bad_sel one cycle", bad_sel, 0);
    start_txn(); repeat (4) tick();
    enter(1, 4);
    chk("R4", "tens strobe in 5th cycle accepted", price, 4);
    repeat (6) tick();
    start_txn();
    key_press = 1'b1; key_digit = 4'd1; tick(); key_press = 1'b0;
    repeat (4) tick();
    chk("R4", "no flag before units timeout", bad_sel, 0);
    tick();
    chk("R4", "units digit timeout", bad_sel, 1);
    tick();
  endtask

  task automatic t_bad_codes();
    start_txn(); enter(2, 3);
    chk("R5", "code 23 rejected", bad_sel, 1);
    chk("R5", "price stays 0", price, 0);
    tick();
    start_txn(); enter(2, 0);
    chk("R5", "code 20 rejected", bad_sel, 1);
    tick();
    start_txn(); enter(0, 12);
    chk("R5", "units digit above 9 rejected", bad_sel, 1);
    tick();
  endtask

  task automatic t_drain();
    do_reset(); reload_idle(); tick();
    for (int n = 0; n < 10; n++) buy(1, 9, "R8");
    start_txn(); enter(1, 9);
    chk("R8", "11th sale of slot rejected", bad_sel, 1);
    tick();
    start_txn(); reload = 1'b1; enter(1, 9);
    chk("R2", "reload in transaction ignored", bad_sel, 1);
    reload = 1'b0; tick();
    start_txn(); enter(1, 9);
    chk("R2", "slot still empty", bad_sel, 1);
    tick();
    reload_idle(); tick();
    buy(1, 9, "R2");
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    report();
  end

  initial begin
    t_reset();
    t_reload_beats_card();
    reload_idle(); tick();
    buy(1, 6, "R3");
    t_gap_digits();
    t_price_sweep();
    t_late_approval();
    t_digit_timeouts();
    t_bad_codes();
    t_drain();
    report();
  end
endmodule